// File: doc/BRIEF.md
# Dual-Half LUT RAM Logic Cell

This cell holds two 32-bit lookup halves, A and B. Each half is used either as a 16-word by 2-bit memory or as a lookup of one five-input function. A mode register sets which of three arrangements is active. The first joins both halves into one 16x4 memory on a single address. The second uses half A as a 16x2 memory and half B as a five-input function. The third uses both halves as five-input functions. In every arrangement the read path is combinational and the write path is clocked.

Half A takes its write enable on a_we_i and half B on b_we_i. Each enable counts only while the shared write-port enable wpe_i is high, so a decode of upper address bits driven onto wpe_i picks one bank out of several cells wired in parallel for deeper memories. The contents and the mode are loaded together through a parallel preload port.

Storage bit index is {sel, addr}. In memory use, word k has its upper bit at index 16+k and its lower bit at index k. In function use, the lookup index is {pin4, addr}. A preloaded table can therefore be read back word by word in a memory mode.

Top module: `lut_ram_cell`

## Requirements
- R1: After reset both halves hold all zeros and the mode is logic (00), so f_o reads 0000.
- R2: When preload_en_i is high at a rising edge, half A takes preload_data_i[31:0], half B takes preload_data_i[63:32] and the mode takes preload_mode_i. A preload wins over any write in the same cycle.
- R3: In mode 01 (16x4), with address a = a_addr_i, f_o = {A[16+a], A[a], B[16+a], B[a]} combinationally. b_addr_i has no effect in this mode.
- R4: In mode 01, a rising edge with a_we_i and wpe_i both high writes wd_i[3] to A[16+a] and wd_i[2] to A[a]. A rising edge with b_we_i and wpe_i both high writes wd_i[1] to B[16+a] and wd_i[0] to B[a]. The new word appears on f_o right after that edge.
- R5: With wpe_i low, no write takes place in either half, whatever a_we_i and b_we_i are.
- R6: A half writes only when its own enable is high: a_we_i alone leaves half B unchanged, and b_we_i alone leaves half A unchanged.
- R7: In mode 10 (16x2 plus function), half A reads and writes as in R3 and R4 on a_addr_i. f_o[1] is 0 and f_o[0] = B[{b_we_i, b_addr_i}]. Half B is never written in this mode.
- R8: In mode 00 (logic), f_o = {A[{a_we_i, a_addr_i}], 0, 0, B[{b_we_i, b_addr_i}]}. Writes are ignored.
- R9: Mode 11 behaves exactly like mode 00.
- R10: A table preloaded in one mode reads back under the bit layout {sel, addr} in every other mode, with no reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| preload_en_i | input | 1 | Load contents and mode at the next edge |
| preload_mode_i | input | 2 | Mode value to load |
| preload_data_i | input | 64 | Half B bits [63:32], half A bits [31:0] |
| a_addr_i | input | 4 | Half A address and shared 16x4 address |
| a_we_i | input | 1 | Half A write enable, fifth lookup input of half A |
| b_addr_i | input | 4 | Half B address / lookup input |
| b_we_i | input | 1 | Half B write enable, fifth lookup input of half B |
| wpe_i | input | 1 | Shared write-port enable |
| wd_i | input | 4 | Write data, [3:2] to half A, [1:0] to half B |
| f_o | output | 4 | Read or function output |

## Verification
The bench drives a random mix of addresses, enables, write data and occasional preloads. In each mode, an output mismatch points to a specific fault. In 16x4 mode a mismatch shows a wrong shared address, a wrong data lane or a wrong write gate. In mixed mode it shows whether half B is wrongly written, or is read from the memory address instead of {b_we_i, b_addr_i}. Logic mode and the reserved code show whether writes leak through. Directed cases come first. They drop wpe_i, raise one enable at a time and read a preloaded pattern back, which separates the AND-gated strobe from the per-half enable and confirms the bit layout.

// File: rtl/lut_ram_cell.sv
module lut_ram_cell #(
  parameter int AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   preload_en_i,
  input  logic [1:0]             preload_mode_i,
  input  logic [4*(1<<AW)-1:0]   preload_data_i,
  input  logic [AW-1:0]          a_addr_i,
  input  logic                   a_we_i,
  input  logic [AW-1:0]          b_addr_i,
  input  logic                   b_we_i,
  input  logic                   wpe_i,
  input  logic [3:0]             wd_i,
  output logic [3:0]             f_o
);
  localparam int WORDS = 1 << AW;
  localparam int BITS  = 2 * WORDS;

  localparam logic [1:0] M_LOGIC = 2'b00;
  localparam logic [1:0] M_RAM4  = 2'b01;
  localparam logic [1:0] M_RAMF5 = 2'b10;

  logic [BITS-1:0] mem_a, mem_b;
  logic [1:0]      mode_q;

  wire is_ram4  = (mode_q == M_RAM4);
  wire is_ramf5 = (mode_q == M_RAMF5);

  wire [AW-1:0] addr_b_ram = a_addr_i;
  wire we_a = wpe_i & a_we_i & (is_ram4 | is_ramf5);
  wire we_b = wpe_i & b_we_i & is_ram4;

  wire [AW:0] hi_a = {1'b1, a_addr_i};
  wire [AW:0] lo_a = {1'b0, a_addr_i};
  wire [AW:0] hi_b = {1'b1, addr_b_ram};
  wire [AW:0] lo_b = {1'b0, addr_b_ram};
  wire [AW:0] lut_a = {a_we_i, a_addr_i};
  wire [AW:0] lut_b = {b_we_i, b_addr_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_a  <= '0;
      mem_b  <= '0;
      mode_q <= M_LOGIC;
    end else if (preload_en_i) begin
      mem_a  <= preload_data_i[BITS-1:0];
      mem_b  <= preload_data_i[2*BITS-1:BITS];
      mode_q <= preload_mode_i;
    end else begin
      if (we_a) begin
        mem_a[hi_a] <= wd_i[3];
        mem_a[lo_a] <= wd_i[2];
      end
      if (we_b) begin
        mem_b[hi_b] <= wd_i[1];
        mem_b[lo_b] <= wd_i[0];
      end
    end
  end

  always_comb begin
    if (is_ram4)
      f_o = {mem_a[hi_a], mem_a[lo_a], mem_b[hi_b], mem_b[lo_b]};
    else if (is_ramf5)
      f_o = {mem_a[hi_a], mem_a[lo_a], 1'b0, mem_b[lut_b]};
    else
      f_o = {mem_a[lut_a], 2'b00, mem_b[lut_b]};
  end

  AST_PRELOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en_i |=> mem_a == $past(preload_data_i[BITS-1:0])); // R2
  AST_PRELOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en_i |=> mem_b == $past(preload_data_i[2*BITS-1:BITS])); // R2
  AST_WPE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wpe_i && !preload_en_i) |=> ($stable(mem_a) && $stable(mem_b))); // R5
  AST_LOGIC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en_i && !mode_q[0] && !mode_q[1]) |=> ($stable(mem_a) && $stable(mem_b))); // R8
  AST_F5_HALF_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en_i && is_ramf5) |=> $stable(mem_b)); // R7
  AST_B_OWN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en_i && !b_we_i) |=> $stable(mem_b)); // R6
  AST_A_OWN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en_i && !a_we_i) |=> $stable(mem_a)); // R6
  AST_F5_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_ramf5 |-> !f_o[1]); // R7
  AST_LOGIC_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ram4 && !is_ramf5) |-> (f_o[2:1] == 2'b00)); // R8
endmodule

// File: tb/test_lut_ram_cell.sv
module test_lut_ram_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preload_en = 1'b0;
  logic [1:0] preload_mode = 2'b00;
  logic [63:0] preload_data = '0;
  logic [3:0] a_addr = '0, b_addr = '0, wd = '0;
  logic a_we = 1'b0, b_we = 1'b0, wpe = 1'b0;
  logic [3:0] f;

  int checks = 0, errors = 0;
  logic [31:0] ref_a = '0, ref_b = '0;
  logic [1:0] ref_mode = 2'b00;

  always #2 clk = ~clk;

  lut_ram_cell i_lut_ram_cell (
    .clk(clk), .rst_n(rst_n), .preload_en_i(preload_en), .preload_mode_i(preload_mode),
    .preload_data_i(preload_data), .a_addr_i(a_addr), .a_we_i(a_we), .b_addr_i(b_addr),
    .b_we_i(b_we), .wpe_i(wpe), .wd_i(wd), .f_o(f));

  function automatic logic [3:0] expect_f();
    int a = a_addr;
    int la = (a_we ? 16 : 0) + a_addr;
    int lb = (b_we ? 16 : 0) + b_addr;
    if (ref_mode == 2'b01) return {ref_a[16+a], ref_a[a], ref_b[16+a], ref_b[a]};
    if (ref_mode == 2'b10) return {ref_a[16+a], ref_a[a], 1'b0, ref_b[lb]};
    return {ref_a[la], 2'b00, ref_b[lb]};
  endfunction

  task automatic check(input string tag);
    logic [3:0] e = expect_f();
    checks++;
    if (f !== e) begin
      errors++;
      $display("FAIL %s f_o=%b expected=%b mode=%b", tag, f, e, ref_mode);
    end
  endtask

  task automatic model_edge();
    int a = a_addr;
    if (preload_en) begin
      ref_a = preload_data[31:0];
      ref_b = preload_data[63:32];
      ref_mode = preload_mode;
    end else if (ref_mode == 2'b01 || ref_mode == 2'b10) begin
      if (wpe && a_we) begin ref_a[16+a] = wd[3]; ref_a[a] = wd[2]; end
      if (wpe && b_we && ref_mode == 2'b01) begin ref_b[16+a] = wd[1]; ref_b[a] = wd[0]; end
    end
  endtask

  task automatic step(input string tag, input logic pe, input logic [1:0] pm, input logic [63:0] pd,
                      input logic [3:0] aa, input logic aw, input logic [3:0] ba, input logic bw,
                      input logic p, input logic [3:0] d);
    @(negedge clk);
    preload_en = pe; preload_mode = pm; preload_data = pd;
    a_addr = aa; a_we = aw; b_addr = ba; b_we = bw; wpe = p; wd = d;
    #1 check(tag);
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset");
    rst_n = 1'b1;
    step("R1 after reset", 0, 0, 0, 4'd7, 1, 4'd3, 1, 1, 4'hF);
    step("R2 preload", 1, 2'b01, 64'hA5C3_0F96_3C5A_E187, 4'd0, 1, 4'd0, 1, 1, 4'hF);
    for (int k = 0; k < 16; k++)
      step("R10 readback", 0, 0, 0, k[3:0], 0, 4'(15 - k), 0, 0, 4'h0);
    step("R5 wpe low", 0, 0, 0, 4'd5, 1, 4'd9, 1, 0, 4'hA);
    step("R5 readback", 0, 0, 0, 4'd5, 0, 4'd1, 0, 0, 4'h0);
    step("R6 only A", 0, 0, 0, 4'd6, 1, 4'd0, 0, 1, 4'h9);
    step("R6 readback A", 0, 0, 0, 4'd6, 0, 4'd2, 0, 0, 4'h0);
    step("R6 only B", 0, 0, 0, 4'd6, 0, 4'd0, 1, 1, 4'h6);
    step("R4 readback", 0, 0, 0, 4'd6, 0, 4'd4, 0, 0, 4'h0);
    step("R3 b_addr ignored", 0, 0, 0, 4'd6, 0, 4'd11, 0, 0, 4'h0);
    step("R2 preload wins", 1, 2'b10, 64'h1234_5678_9ABC_DEF0, 4'd2, 1, 4'd2, 1, 1, 4'hF);
    step("R7 mixed write", 0, 0, 0, 4'd2, 1, 4'd2, 1, 1, 4'h5);
    step("R7 mixed read", 0, 0, 0, 4'd2, 0, 4'd2, 1, 0, 4'h0);
    step("R9 to mode 11", 1, 2'b11, 64'hFFFF_0000_0F0F_F0F0, 4'd1, 0, 4'd1, 0, 0, 4'h0);
    step("R9 write ignored", 0, 0, 0, 4'd1, 1, 4'd1, 1, 1, 4'h0);
    step("R9 readback", 0, 0, 0, 4'd1, 1, 4'd1, 1, 0, 4'h0);
    for (int n = 0; n < 2000; n++) begin
      logic pe = ($urandom_range(0, 19) == 0);
      string tag = (ref_mode == 2'b01) ? "R3 R4 random" :
                   (ref_mode == 2'b10) ? "R7 random" :
                   (ref_mode == 2'b00) ? "R8 random" : "R9 random";
      step(tag, pe, 2'($urandom_range(0, 3)), {$urandom(), $urandom()},
           4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule